// File: doc/BRIEF.md
# Threshold-Gated Adaptive Mesh Route Computation

This block is the route-computation stage of a five-port router in a two-dimensional mesh. Each router has a north, a south, an east, a west and a local port, and is addressed by a horizontal coordinate x and a vertical coordinate y. Flits pass through the block on a valid/ready stream. When a head flit arrives, the block works out which output ports bring the packet closer to its destination. The flit's route fields are presented with the flit one register stage later.

Every head flit carries two numbers. One counts how often the packet has already found its chosen output buffer full. The other is the packet's latency so far in cycles. While the packet is not past both thresholds, the block offers every productive minimal direction. It names a primary port, and also an alternative port that a later allocator can use when the primary port is full. Once both numbers exceed their thresholds, the packet is pinned to one X-then-Y dimension-order port. The thresholds are plain input pins; the suggested values are 20 for the count and 400 for the latency.

Body and tail flits are not routed again. They leave with the route latched from the most recent head flit. Back-pressure works as a single pipeline stage. The input is ready when the output register is empty, or when its content is being taken in the same cycle. While out_vld is high and out_rdy is low, everything on the output holds.

Top module: `mesh_route_compute`

## Requirements
- R1: Port codes are LOCAL=0, NORTH=1, SOUTH=2, EAST=3, WEST=4. The X direction is EAST when dst_x > cur_x and WEST when dst_x < cur_x. The Y direction is NORTH when dst_y > cur_y and SOUTH when dst_y < cur_y.
- R2: When the destination equals the current router, out_pri and out_alt are both LOCAL and out_single is 1, in either mode.
- R3: In adaptive mode with both X and Y productive, out_pri is the X direction, out_alt is the Y direction, out_single is 0 and out_dor is 0.
- R4: In adaptive mode with exactly one productive direction, out_pri and out_alt both equal that direction and out_single is 1.
- R5: Dimension-order mode applies when in_fob > thr_fob and in_lat > thr_lat. It sets out_dor to 1 and out_single to 1. out_pri and out_alt are the X direction if X is productive, otherwise the Y direction.
- R6: A count or latency equal to its threshold does not count as exceeding it. If only one of the two exceeds its threshold, the packet stays in adaptive mode (out_dor is 0).
- R7: A flit with in_head=0 leaves with the route of the most recent head flit. Its own destination, count and latency have no effect on the route outputs.
- R8: A flit accepted on a clock edge (in_vld and in_rdy both 1) appears on the output at that edge with out_vld=1. out_head, out_tail and out_data are copied from the input. in_rdy equals !out_vld || out_rdy. While out_vld=1 and out_rdy=0, all outputs hold.
- R9: During and straight after reset, out_vld is 0 and in_rdy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cur_x | input | X_W | This router's x coordinate |
| cur_y | input | Y_W | This router's y coordinate |
| thr_fob | input | FOB_W | Full-buffer count threshold |
| thr_lat | input | LAT_W | Latency threshold |
| in_vld | input | 1 | Input flit valid |
| in_rdy | output | 1 | Input flit accepted when high with in_vld |
| in_head | input | 1 | Flit is a head flit |
| in_tail | input | 1 | Flit is a tail flit |
| in_dst_x | input | X_W | Destination x (head flits) |
| in_dst_y | input | Y_W | Destination y (head flits) |
| in_fob | input | FOB_W | Full-buffer encounter count (head flits) |
| in_lat | input | LAT_W | Current packet latency (head flits) |
| in_data | input | DATA_W | Flit payload |
| out_vld | output | 1 | Output flit valid |
| out_rdy | input | 1 | Downstream ready |
| out_head | output | 1 | Head marker of the output flit |
| out_tail | output | 1 | Tail marker of the output flit |
| out_data | output | DATA_W | Payload of the output flit |
| out_pri | output | 3 | Primary output port code |
| out_alt | output | 3 | Alternative output port code |
| out_single | output | 1 | Only one choice is offered |
| out_dor | output | 1 | Packet is in dimension-order mode |

## Verification
The bench builds the block for a 4x4 mesh (2-bit coordinates), a 5-bit count and a 9-bit latency, with the thresholds at 20 and 400. At this size it can sweep every pair of router and destination, all 256 of them, once in adaptive mode and once in dimension-order mode. It also steps the count and the latency through threshold-1, threshold and threshold+1, in every combination, which covers the equality and one-sided cases. Directed sequences then check that body flits keep the head's route, and that the output holds under a stall.

// File: rtl/mrc_pkg.sv
package mrc_pkg;
  localparam int PORT_W = 3;
  typedef logic [PORT_W-1:0] port_t;
  localparam port_t P_LOCAL = 3'd0;
  localparam port_t P_NORTH = 3'd1;
  localparam port_t P_SOUTH = 3'd2;
  localparam port_t P_EAST  = 3'd3;
  localparam port_t P_WEST  = 3'd4;
  localparam int DEF_THR_FOB = 20;
  localparam int DEF_THR_LAT = 400;
endpackage

// File: rtl/mrc_mode_sel.sv
module mrc_mode_sel #(
  parameter int FOB_W = 8,
  parameter int LAT_W = 12
) (
  input  logic [FOB_W-1:0] fob,
  input  logic [FOB_W-1:0] thr_fob,
  input  logic [LAT_W-1:0] lat,
  input  logic [LAT_W-1:0] thr_lat,
  output logic             dor
);
  logic fob_over, lat_over;
  always_comb begin
    fob_over = fob > thr_fob;
    lat_over = lat > thr_lat;
    dor      = fob_over && lat_over;
  end
endmodule

// File: rtl/mrc_dir_calc.sv
module mrc_dir_calc
  import mrc_pkg::*;
#(
  parameter int X_W = 3,
  parameter int Y_W = 3
) (
  input  logic [X_W-1:0] cur_x,
  input  logic [Y_W-1:0] cur_y,
  input  logic [X_W-1:0] dst_x,
  input  logic [Y_W-1:0] dst_y,
  input  logic           dor,
  output port_t          pri,
  output port_t          alt,
  output logic           single
);
  port_t xdir, ydir;
  logic  x_go, y_go;

  always_comb begin
    x_go = dst_x != cur_x;
    y_go = dst_y != cur_y;
    xdir = (dst_x > cur_x) ? P_EAST  : P_WEST;
    ydir = (dst_y > cur_y) ? P_NORTH : P_SOUTH;
    if (!x_go && !y_go) begin
      pri    = P_LOCAL;
      alt    = P_LOCAL;
      single = 1'b1;
    end else if (x_go && y_go && !dor) begin
      pri    = xdir;
      alt    = ydir;
      single = 1'b0;
    end else begin
      pri    = x_go ? xdir : ydir;
      alt    = pri;
      single = 1'b1;
    end
  end

  always_comb begin
    AST_SINGLE_SAME: assert (!single || pri == alt);            // R4
    AST_PAIR_DIFFER: assert (single || (pri != alt && pri != P_LOCAL && alt != P_LOCAL)); // R3
    AST_LOCAL_ONLY:  assert ((pri == P_LOCAL) == (!x_go && !y_go)); // R2
  end
endmodule

// File: rtl/mesh_route_compute.sv
module mesh_route_compute
  import mrc_pkg::*;
#(
  parameter int X_W    = 3,
  parameter int Y_W    = 3,
  parameter int FOB_W  = 8,
  parameter int LAT_W  = 12,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [X_W-1:0]    cur_x,
  input  logic [Y_W-1:0]    cur_y,
  input  logic [FOB_W-1:0]  thr_fob,
  input  logic [LAT_W-1:0]  thr_lat,
  input  logic              in_vld,
  output logic              in_rdy,
  input  logic              in_head,
  input  logic              in_tail,
  input  logic [X_W-1:0]    in_dst_x,
  input  logic [Y_W-1:0]    in_dst_y,
  input  logic [FOB_W-1:0]  in_fob,
  input  logic [LAT_W-1:0]  in_lat,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_vld,
  input  logic              out_rdy,
  output logic              out_head,
  output logic              out_tail,
  output logic [DATA_W-1:0] out_data,
  output logic [PORT_W-1:0] out_pri,
  output logic [PORT_W-1:0] out_alt,
  output logic              out_single,
  output logic              out_dor
);
  logic  calc_dor, calc_single;
  port_t calc_pri, calc_alt;
  port_t hold_pri, hold_alt;
  logic  hold_single, hold_dor;
  logic  take;

  mrc_mode_sel #(.FOB_W(FOB_W), .LAT_W(LAT_W)) i_mode (
    .fob(in_fob), .thr_fob(thr_fob), .lat(in_lat), .thr_lat(thr_lat), .dor(calc_dor)
  );

  mrc_dir_calc #(.X_W(X_W), .Y_W(Y_W)) i_dir (
    .cur_x(cur_x), .cur_y(cur_y), .dst_x(in_dst_x), .dst_y(in_dst_y),
    .dor(calc_dor), .pri(calc_pri), .alt(calc_alt), .single(calc_single)
  );

  assign in_rdy = !out_vld || out_rdy;
  assign take   = in_vld && in_rdy;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_vld     <= 1'b0;
      out_head    <= 1'b0;
      out_tail    <= 1'b0;
      out_data    <= '0;
      out_pri     <= P_LOCAL;
      out_alt     <= P_LOCAL;
      out_single  <= 1'b1;
      out_dor     <= 1'b0;
      hold_pri    <= P_LOCAL;
      hold_alt    <= P_LOCAL;
      hold_single <= 1'b1;
      hold_dor    <= 1'b0;
    end else begin
      if (in_rdy) out_vld <= in_vld;
      if (take) begin
        out_head <= in_head;
        out_tail <= in_tail;
        out_data <= in_data;
        if (in_head) begin
          out_pri     <= calc_pri;
          out_alt     <= calc_alt;
          out_single  <= calc_single;
          out_dor     <= calc_dor;
          hold_pri    <= calc_pri;
          hold_alt    <= calc_alt;
          hold_single <= calc_single;
          hold_dor    <= calc_dor;
        end else begin
          out_pri     <= hold_pri;
          out_alt     <= hold_alt;
          out_single  <= hold_single;
          out_dor     <= hold_dor;
        end
      end
    end
  end

  AST_STALL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && !out_rdy |=> out_vld && $stable(out_pri) && $stable(out_alt) && $stable(out_data) && $stable(out_tail)); // R8
  AST_DOR_IS_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && out_dor |-> out_single); // R5
  AST_BODY_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    take && !in_head && out_vld && !out_head |=> $stable(out_pri) && $stable(out_alt)); // R7
  AST_LOCAL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    out_vld && out_pri == P_LOCAL |-> out_single && out_alt == P_LOCAL); // R2
endmodule

// File: tb/test_mesh_route_compute.sv
`timescale 1ns/1ps
module test_mesh_route_compute;
  localparam int XW = 2, YW = 2, FW = 5, LW = 9, DW = 8;
  localparam int TF = 20, TL = 400;

  logic clk = 0, rst_n = 0;
  logic [XW-1:0] cur_x; logic [YW-1:0] cur_y;
  logic [FW-1:0] thr_fob; logic [LW-1:0] thr_lat;
  logic in_vld, in_rdy, in_head, in_tail;
  logic [XW-1:0] in_dst_x; logic [YW-1:0] in_dst_y;
  logic [FW-1:0] in_fob; logic [LW-1:0] in_lat; logic [DW-1:0] in_data;
  logic out_vld, out_rdy, out_head, out_tail, out_single, out_dor;
  logic [DW-1:0] out_data; logic [2:0] out_pri, out_alt;
  int checks = 0, errors = 0;

  always #2 clk = ~clk;

  mesh_route_compute #(.X_W(XW), .Y_W(YW), .FOB_W(FW), .LAT_W(LW), .DATA_W(DW)) i_mesh_route_compute (
    .clk, .rst_n, .cur_x, .cur_y, .thr_fob, .thr_lat, .in_vld, .in_rdy, .in_head, .in_tail,
    .in_dst_x, .in_dst_y, .in_fob, .in_lat, .in_data, .out_vld, .out_rdy, .out_head, .out_tail,
    .out_data, .out_pri, .out_alt, .out_single, .out_dor);

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic expect_route(input int cx, cy, dx, dy, input bit dor,
                              output int p, output int a, output int s);
    int xd, yd;
    xd = dx > cx ? 3 : (dx < cx ? 4 : 0);
    yd = dy > cy ? 1 : (dy < cy ? 2 : 0);
    if (xd == 0 && yd == 0) begin p = 0; a = 0; s = 1; end
    else if (!dor && xd != 0 && yd != 0) begin p = xd; a = yd; s = 0; end
    else begin p = (xd != 0) ? xd : yd; a = p; s = 1; end
  endtask

  task automatic drive(input bit h, t, input int dx, dy, f, l, d);
    in_vld = 1; in_head = h; in_tail = t; in_dst_x = dx[XW-1:0]; in_dst_y = dy[YW-1:0];
    in_fob = f[FW-1:0]; in_lat = l[LW-1:0]; in_data = d[DW-1:0];
  endtask

  task automatic route_check(input string req, input int p, a, s, dor);
    chk(req, out_pri, p); chk(req, out_alt, a);
    chk(req, out_single, s); chk(req, out_dor, dor);
  endtask

  initial begin
    #200000;
    errors++; checks++;
    $display("FAIL watchdog actual 0 expected 1");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int p, a, s;
    thr_fob = TF; thr_lat = TL; out_rdy = 1; cur_x = 0; cur_y = 0;
    in_vld = 0; in_head = 0; in_tail = 0; in_dst_x = 0; in_dst_y = 0;
    in_fob = 0; in_lat = 0; in_data = 0;
    repeat (3) @(negedge clk);
    chk("R9 out_vld", out_vld, 0); chk("R9 in_rdy", in_rdy, 1);
    rst_n = 1;
    @(negedge clk);
    chk("R9 out_vld after", out_vld, 0);

    // full sweep, adaptive then dimension-order: R1 R2 R3 R4 R5
    for (int m = 0; m < 2; m++)
      for (int cx = 0; cx < 4; cx++)
        for (int cy = 0; cy < 4; cy++)
          for (int dx = 0; dx < 4; dx++)
            for (int dy = 0; dy < 4; dy++) begin
              cur_x = cx[XW-1:0]; cur_y = cy[YW-1:0];
              drive(1, 1, dx, dy, m ? 31 : 0, m ? 511 : 0, dx*16 + dy);
              @(negedge clk);
              expect_route(cx, cy, dx, dy, m == 1, p, a, s);
              chk("R8 valid", out_vld, 1);
              chk("R8 data", out_data, dx*16 + dy);
              route_check(m ? "R5 sweep" : "R1 R3 R4 sweep", p, a, s, m);
              if (dx == cx && dy == cy) chk("R2 local", out_pri, 0);
            end

    // threshold boundaries: R6
    cur_x = 1; cur_y = 1;
    for (int fi = -1; fi <= 1; fi++)
      for (int li = -1; li <= 1; li++) begin
        bit d;
        d = (fi > 0) && (li > 0);
        drive(1, 1, 3, 3, TF + fi, TL + li, 0);
        @(negedge clk);
        expect_route(1, 1, 3, 3, d, p, a, s);
        route_check("R6 boundary", p, a, s, d);
      end

    // body flits keep head route: R7
    cur_x = 2; cur_y = 2;
    drive(1, 0, 0, 3, 0, 0, 1);
    @(negedge clk);
    route_check("R7 head", 4, 1, 0, 0);
    drive(0, 0, 2, 2, 31, 511, 2);
    @(negedge clk);
    route_check("R7 body", 4, 1, 0, 0);
    chk("R8 head flag", out_head, 0);
    drive(0, 1, 3, 0, 31, 511, 3);
    @(negedge clk);
    route_check("R7 tail", 4, 1, 0, 0);
    chk("R8 tail flag", out_tail, 1);

    // stall: R8
    in_vld = 0;
    @(negedge clk);
    chk("R8 drained", out_vld, 0);
    out_rdy = 0;
    drive(1, 1, 3, 2, 0, 0, 8'h5A);
    @(negedge clk);
    chk("R8 stalled valid", out_vld, 1);
    chk("R8 in_rdy low", in_rdy, 0);
    route_check("R8 A", 3, 3, 1, 0);
    drive(1, 1, 2, 3, 0, 0, 8'hA5);
    @(negedge clk);
    chk("R8 hold data", out_data, 8'h5A);
    route_check("R8 hold", 3, 3, 1, 0);
    out_rdy = 1;
    @(negedge clk);
    chk("R8 next data", out_data, 8'hA5);
    route_check("R8 B", 1, 1, 1, 0);
    in_vld = 0;
    @(negedge clk);
    chk("R8 empty", out_vld, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule